// File: doc/BRIEF.md
# Nested Loop Context Stack

This block stores the contexts of nested zero-overhead hardware loops. A context is three values: an iteration count, the address of the first instruction of the loop body and the address of its last instruction. Level 0 always holds the innermost, currently running loop. Its three values are driven straight to outputs so that a fetch unit can compare against them with no extra cycle. Deeper levels hold the enclosing loops.

Entering a loop pushes a new context. The new context goes into level 0 and every older context moves one level deeper. Leaving a loop pops: every level moves one step toward level 0, and the deepest level is cleared. Any single stored value can be read or rewritten through one flat index. Counts sit at indices 0 to 3 (levels 0 to 3), start addresses at 4 to 7, and end addresses at 8 to 11. This serves context save and restore around interrupts.

The stack does not decrement counts and does not redirect fetch. A small classifier turns the request pins into one operation per cycle: IDLE, PUSH, POP, SWAP (push and pop together), WRITE or REJECT (a push into a full stack). A two-state flag machine records overflow. It moves from FLAG_CLEAR to FLAG_LATCHED on a REJECT, stays in FLAG_LATCHED until reset, and otherwise stays in FLAG_CLEAR.

Top module: `loopstk_top`

## Requirements
- R1: After reset every stored value at all levels reads zero, the level-0 outputs are zero and the overflow flag is low.
- R2: A push loads the pushed count, start and end into level 0 and moves each level i to level i+1, visible on the level-0 outputs and through readback in the cycle after the push edge.
- R3: A pop moves each level i+1 to level i and clears all three values of the deepest level.
- R4: A push while the deepest level is occupied is rejected: no stored value changes, and the overflow flag rises after that edge and stays high until reset.
- R5: A push and a pop in the same cycle replace only the level-0 context, never count as overflow, and leave deeper levels unchanged.
- R6: Readback index 0..3 returns the count of level 0..3 zero-extended to 32 bits, 4..7 the start address of level 0..3, and 8..11 the end address of level 0..3, in the same cycle the index is presented.
- R7: A readback index of 12 or more returns all ones. The error output is high in that same cycle only when the read enable is also high, and it is low for every valid index.
- R8: A write with a valid index replaces exactly one stored value at the clock edge, a count keeping the low 16 bits of the write data. The write is ignored when push or pop is active in the same cycle, and also when the index is 12 or more.
- R9: The deepest level counts as occupied when any of its three values is non-zero, so a context pushed as all zeros can later be shifted out without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push a new context |
| pop_i | input | 1 | Pop the innermost context |
| push_cnt_i | input | 16 | Iteration count of the pushed context |
| push_start_i | input | 32 | Loop start address of the pushed context |
| push_end_i | input | 32 | Loop end address of the pushed context |
| wr_en_i | input | 1 | Indexed write request |
| wr_idx_i | input | 4 | Flat index of the value to write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Readback enable, qualifies the error output |
| rd_idx_i | input | 4 | Flat readback index |
| rd_data_o | output | 32 | Readback value |
| rd_err_o | output | 1 | Invalid readback index while enabled |
| cur_cnt_o | output | 16 | Level-0 count |
| cur_start_o | output | 32 | Level-0 start address |
| cur_end_o | output | 32 | Level-0 end address |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench fills the stack with an all-zero context at the bottom and then pushes once more. A design that judged occupancy by level count, or by the count field alone, would flag overflow there or drop the wrong entry. It then pushes into a really full stack: a design that lets the push through loses the outermost loop, and one that clears the flag early hides the error. Push and pop together must leave deeper levels untouched, and a design that treats this as a pop followed by a push would move them. Writes that collide with a pop or use out-of-range indices must not disturb any stored value, and invalid reads must give all ones with the error raised only while enabled.

// File: rtl/loopstk_pkg.sv
package loopstk_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_WRITE,
        OP_REJECT
    } stk_op_e;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_LATCHED
    } ovf_state_e;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/loopstk_ctrl.sv
module loopstk_ctrl
    import loopstk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    wr_req_i,
    input  logic    deep_busy_i,
    output stk_op_e op_o,
    output logic    ovf_o
);

    ovf_state_e st_q, st_d;

    always_comb begin
        if (push_i && pop_i)       op_o = OP_SWAP;
        else if (push_i)           op_o = deep_busy_i ? OP_REJECT : OP_PUSH;
        else if (pop_i)            op_o = OP_POP;
        else if (wr_req_i)         op_o = OP_WRITE;
        else                       op_o = OP_IDLE;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_CLEAR:   st_d = (op_o == OP_REJECT) ? FLAG_LATCHED : FLAG_CLEAR;
            FLAG_LATCHED: st_d = FLAG_LATCHED;
            default:      st_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb ovf_o = (st_q == FLAG_LATCHED);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R4
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && deep_busy_i) |=> ovf_o); // R4
    AST_SWAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && push_i && pop_i) |=> !ovf_o); // R5

endmodule

// File: rtl/loopstk_lane.sv
module loopstk_lane
    import loopstk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  stk_op_e                  op_i,
    input  logic [W-1:0]             new_i,
    input  logic [DEPTH-1:0]         wr_sel_i,
    input  logic [W-1:0]             wr_val_i,
    output logic [DEPTH-1:0][W-1:0]  lvl_o
);

    logic [DEPTH-1:0][W-1:0] lvl_q, lvl_d;

    always_comb begin
        lvl_d = lvl_q;
        unique case (op_i)
            OP_PUSH: begin
                lvl_d[0] = new_i;
                for (int i = 1; i < DEPTH; i++) lvl_d[i] = lvl_q[i-1];
            end
            OP_POP: begin
                for (int i = 0; i < DEPTH-1; i++) lvl_d[i] = lvl_q[i+1];
                lvl_d[DEPTH-1] = '0;
            end
            OP_SWAP: lvl_d[0] = new_i;
            OP_WRITE: begin
                for (int i = 0; i < DEPTH; i++)
                    if (wr_sel_i[i]) lvl_d[i] = wr_val_i;
            end
            default: lvl_d = lvl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> (lvl_q[0] == $past(new_i)) &&
                            (lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-2]))); // R2
    AST_POP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=> (lvl_q[DEPTH-1] == '0) &&
                           (lvl_q[0] == $past(lvl_q[1]))); // R3
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_REJECT |=> $stable(lvl_q)); // R4
    AST_SWAP_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SWAP |=> $stable(lvl_q[DEPTH-1:1])); // R5

endmodule

// File: rtl/loopstk_rdmux.sv
module loopstk_rdmux
    import loopstk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic [NUM_LANES-1:0][DEPTH-1:0][W-1:0] lanes_i,
    input  logic                                   rd_en_i,
    input  logic [IDX_W-1:0]                       rd_idx_i,
    output logic [W-1:0]                           rd_data_o,
    output logic                                   rd_err_o
);

    logic hit;

    always_comb begin
        rd_data_o = '1;
        hit       = 1'b0;
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (rd_idx_i == IDX_W'(l*DEPTH + k)) begin
                    rd_data_o = lanes_i[l][k];
                    hit       = 1'b1;
                end
            end
        end
        rd_err_o = rd_en_i && !hit;
    end

endmodule

// File: rtl/loopstk_top.sv
module loopstk_top
    import loopstk_pkg::*;
#(
    parameter int  DEPTH  = 4,
    parameter int  CNT_W  = 16,
    parameter int  ADDR_W = 32,
    localparam int NENT   = NUM_LANES * DEPTH,
    localparam int IDX_W  = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    input  logic [ADDR_W-1:0] push_start_i,
    input  logic [ADDR_W-1:0] push_end_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o,
    output logic              rd_err_o,
    output logic [CNT_W-1:0]  cur_cnt_o,
    output logic [ADDR_W-1:0] cur_start_o,
    output logic [ADDR_W-1:0] cur_end_o,
    output logic              ovf_o
);

    localparam int LANE_CNT   = 0;
    localparam int LANE_START = 1;
    localparam int LANE_END   = 2;

    stk_op_e                                    op;
    logic [NUM_LANES-1:0][DEPTH-1:0]            wr_sel;
    logic                                       wr_hit;
    logic                                       deep_busy;
    logic [DEPTH-1:0][CNT_W-1:0]                cnt_lvl;
    logic [DEPTH-1:0][ADDR_W-1:0]               start_lvl;
    logic [DEPTH-1:0][ADDR_W-1:0]               end_lvl;
    logic [NUM_LANES-1:0][DEPTH-1:0][ADDR_W-1:0] flat;

    // flat index decode for writes: lane = idx / DEPTH, level = idx % DEPTH
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_wsel
        for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
            assign wr_sel[l][k] = (wr_idx_i == IDX_W'(l*DEPTH + k));
        end
    end
    assign wr_hit = |wr_sel;

    assign deep_busy = (|cnt_lvl[DEPTH-1]) | (|start_lvl[DEPTH-1]) | (|end_lvl[DEPTH-1]);

    loopstk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .wr_req_i    (wr_en_i && wr_hit),
        .deep_busy_i (deep_busy),
        .op_o        (op),
        .ovf_o       (ovf_o)
    );

    loopstk_lane #(.DEPTH(DEPTH), .W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .new_i    (push_cnt_i),
        .wr_sel_i (wr_sel[LANE_CNT]),
        .wr_val_i (wr_data_i[CNT_W-1:0]),
        .lvl_o    (cnt_lvl)
    );

    loopstk_lane #(.DEPTH(DEPTH), .W(ADDR_W)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .new_i    (push_start_i),
        .wr_sel_i (wr_sel[LANE_START]),
        .wr_val_i (wr_data_i),
        .lvl_o    (start_lvl)
    );

    loopstk_lane #(.DEPTH(DEPTH), .W(ADDR_W)) u_end (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .new_i    (push_end_i),
        .wr_sel_i (wr_sel[LANE_END]),
        .wr_val_i (wr_data_i),
        .lvl_o    (end_lvl)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_flat
        assign flat[LANE_CNT][k]   = {{(ADDR_W-CNT_W){1'b0}}, cnt_lvl[k]};
        assign flat[LANE_START][k] = start_lvl[k];
        assign flat[LANE_END][k]   = end_lvl[k];
    end

    loopstk_rdmux #(.DEPTH(DEPTH), .W(ADDR_W), .IDX_W(IDX_W)) u_rd (
        .lanes_i   (flat),
        .rd_en_i   (rd_en_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o),
        .rd_err_o  (rd_err_o)
    );

    assign cur_cnt_o   = cnt_lvl[0];
    assign cur_start_o = start_lvl[0];
    assign cur_end_o   = end_lvl[0];

    AST_BAD_IDX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> (&rd_data_o)); // R7
    AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pop_i && !push_i) |=> (end_lvl[DEPTH-1] == '0)); // R8

endmodule

// File: tb/tb_loopstk_top.sv
`timescale 1ns/1ps
module tb_loopstk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 0, pop = 0, wr_en = 0, rd_en = 0;
    logic [15:0] push_cnt = '0;
    logic [31:0] push_start = '0, push_end = '0, wr_data = '0;
    logic [3:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] rd_data, cur_start, cur_end;
    logic [15:0] cur_cnt;
    logic        rd_err, ovf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    loopstk_top dut (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .push_cnt_i(push_cnt), .push_start_i(push_start), .push_end_i(push_end),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_err_o(rd_err),
        .cur_cnt_o(cur_cnt), .cur_start_o(cur_start), .cur_end_o(cur_end), .ovf_o(ovf)
    );

    // reference model built from the requirements
    logic [15:0] m_cnt [4];
    logic [31:0] m_st  [4];
    logic [31:0] m_en  [4];
    logic        m_ovf;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        ovf;
        logic [15:0] c;
        logic [31:0] s;
        logic [31:0] e;
        string       tag;
    } item_t;
    item_t q[$];

    function automatic logic [31:0] exp_rd(input int idx);
        if (idx < 4)       return {16'h0, m_cnt[idx]};
        else if (idx < 8)  return m_st[idx-4];
        else if (idx < 12) return m_en[idx-8];
        else               return 32'hFFFF_FFFF;
    endfunction

    // driver: present a read and hand the expectation to the monitor
    task automatic check_rd(input int idx, input logic en, input string tag);
        item_t it;
        @(negedge clk);
        rd_en  = en;
        rd_idx = idx[3:0];
        it.data = exp_rd(idx);
        it.err  = en && (idx > 11);
        it.ovf  = m_ovf;
        it.c = m_cnt[0]; it.s = m_st[0]; it.e = m_en[0];
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 12; i++) check_rd(i, 1'b1, tag);
    endtask

    // monitor: compare outputs a little after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (rd_data !== it.data || rd_err !== it.err) begin
                    errors++;
                    $display("FAIL %s idx=%0d: data=%h err=%b expected data=%h err=%b",
                             it.tag, rd_idx, rd_data, rd_err, it.data, it.err);
                end
                checks++;
                if (ovf !== it.ovf) begin
                    errors++;
                    $display("FAIL %s ovf: actual=%b expected=%b", it.tag, ovf, it.ovf);
                end
                checks++;
                if (cur_cnt !== it.c || cur_start !== it.s || cur_end !== it.e) begin
                    errors++;
                    $display("FAIL %s level0: actual=%h/%h/%h expected=%h/%h/%h",
                             it.tag, cur_cnt, cur_start, cur_end, it.c, it.s, it.e);
                end
            end
        end
    end

    task automatic drive(input logic pu, input logic po, input logic we,
                         input int widx, input logic [31:0] wdat,
                         input logic [15:0] c, input logic [31:0] s, input logic [31:0] e);
        logic busy;
        @(negedge clk);
        push = pu; pop = po; wr_en = we; wr_idx = widx[3:0]; wr_data = wdat;
        push_cnt = c; push_start = s; push_end = e;
        @(posedge clk);
        #1;
        push = 0; pop = 0; wr_en = 0;
        busy = (m_cnt[3] != 0) || (m_st[3] != 0) || (m_en[3] != 0);
        if (pu && po) begin
            m_cnt[0] = c; m_st[0] = s; m_en[0] = e;
        end else if (pu) begin
            if (busy) m_ovf = 1'b1;
            else begin
                for (int i = 3; i > 0; i--) begin
                    m_cnt[i] = m_cnt[i-1]; m_st[i] = m_st[i-1]; m_en[i] = m_en[i-1];
                end
                m_cnt[0] = c; m_st[0] = s; m_en[0] = e;
            end
        end else if (po) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = m_cnt[i+1]; m_st[i] = m_st[i+1]; m_en[i] = m_en[i+1];
            end
            m_cnt[3] = '0; m_st[3] = '0; m_en[3] = '0;
        end else if (we && widx < 12) begin
            if (widx < 4)      m_cnt[widx] = wdat[15:0];
            else if (widx < 8) m_st[widx-4] = wdat;
            else               m_en[widx-8] = wdat;
        end
    endtask

    task automatic do_push(input logic [15:0] c, input logic [31:0] s, input logic [31:0] e);
        drive(1'b1, 1'b0, 1'b0, 0, '0, c, s, e);
    endtask

    task automatic do_pop();
        drive(1'b0, 1'b1, 1'b0, 0, '0, '0, '0, '0);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_st[i] = '0; m_en[i] = '0; end
        m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        check_all("R1 reset state");

        do_push(16'h0, 32'h0, 32'h0);                 // all-zero context at bottom
        do_push(16'd5, 32'h0000_0100, 32'h0000_0120);
        check_all("R2 push loads level 0");

        do_push(16'd7, 32'h0000_0200, 32'h0000_0240);
        do_push(16'hBEEF, 32'hA000_0000, 32'hA000_00FC);
        check_all("R6 flat map with full stack");

        do_push(16'd9, 32'h0000_0300, 32'h0000_0330);  // deepest is all zero
        check_all("R9 zero context is free");

        do_push(16'd1, 32'h0000_0400, 32'h0000_0404);  // deepest now occupied
        check_all("R4 overflow rejected");

        do_pop();
        check_all("R3 pop zero fill");

        drive(1'b1, 1'b1, 1'b0, 0, '0, 16'd3, 32'h0000_0500, 32'h0000_0510);
        check_all("R5 push and pop swap");

        drive(1'b0, 1'b0, 1'b1, 5, 32'h1234_5678, '0, '0, '0);
        drive(1'b0, 1'b0, 1'b1, 2, 32'h0001_2345, '0, '0, '0);
        check_all("R8 indexed write");

        drive(1'b0, 1'b1, 1'b1, 9, 32'hDEAD_BEEF, '0, '0, '0);
        check_all("R8 write yields to pop");

        drive(1'b0, 1'b0, 1'b1, 14, 32'hCAFE_F00D, '0, '0, '0);
        check_all("R8 write bad index ignored");

        check_rd(12, 1'b1, "R7 invalid index");
        check_rd(15, 1'b1, "R7 invalid index");
        check_rd(13, 1'b0, "R7 invalid index not enabled");
        check_rd(3,  1'b0, "R7 valid index not enabled");

        do_pop();
        do_pop();
        do_pop();
        check_all("R3 drained stack");

        do_push(16'd2, 32'h0000_0600, 32'h0000_0608);
        check_all("R2 push after drain");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule